// File: doc/BRIEF.md
# Coincident-Event Reset Generator

This block produces a reset pulse when a chosen set of event inputs is held asserted together for long enough. Each event input has an enable bit. The block qualifies only when at least one event is enabled and every enabled event is high in the same cycle. Events whose enable bit is clear are ignored.

While the enabled events stay coincident, a counter counts time-base ticks against a qualification time. That time is selected by a 3-bit code. When the count is reached, the output drives its active level for a width selected by a 2-bit code. After the pulse ends, the block stays locked out until every enabled event has been released. This stops one long key-hold from firing a chain of resets.

The event count and the output polarity are parameters. A three-event instance and a two-event instance are the same module with different settings. All timing is counted from a single tick input, `tb_tick`, which pulses once per 0.5 ms. `TICKS_PER_HALF_MS` scales the pulse-width units and `TICKS_PER_HALF_SEC` scales the qualification units. The states are:

- `S_IDLE`: waiting for coincidence. It goes to `S_QUAL` on coincidence, or straight to `S_PULSE` on coincidence with trigger code 0.
- `S_QUAL`: counting ticks. It goes back to `S_IDLE` if coincidence is lost, and to `S_PULSE` on the final tick.
- `S_PULSE`: output active. It goes to `S_REARM` on the final width tick.
- `S_REARM`: locked out. It goes to `S_IDLE` in the first cycle with no enabled event high.

Top module: `coincident_reset_gen`

## Requirements
- R1: Only enabled events take part. The block can qualify only in cycles where, for every bit with `ev_en`=1, the matching `ev_in` bit is 1. Events with `ev_en`=0 have no effect.
- R2: When `ev_en` is all zero, the output never becomes active, whatever `ev_in` does.
- R3: Trigger code c on `trig_time` gives a qualification time in 0.5 s units, H(c). H(0)=0, and H(c)=c+1 for c from 1 to 7, which gives 0, 1, 1.5, 2, 2.5, 3, 3.5 and 4 s. This is H(c)·`TICKS_PER_HALF_SEC` ticks. The output goes active at the clock edge that samples the final qualifying tick. With code 0, it goes active at the edge that first samples coincidence.
- R4: If coincidence is lost before the qualification time expires, the block returns to `S_IDLE` and the count restarts from zero.
- R5: Pulse code p on `pulse_code` selects 0.5, 1, 5 or 10 ms for p = 0, 1, 2, 3. This is 1, 2, 10 or 20 units of `TICKS_PER_HALF_MS` ticks. The output returns to its inactive level at the edge that samples the final width tick.
- R6: After a pulse ends, the block does not trigger again until a cycle occurs with no enabled event high. Releasing only some of the events does not re-arm it.
- R7: While `rst_n` is low, and right after it is released, the output is at its inactive level and the state is `S_IDLE`.
- R8: `NUM_EVENTS` sets the number of event inputs. A 2-event instance follows R1 to R6 on its two inputs.
- R9: With `ACTIVE_HIGH`=1, the active level of `rst_out` is 1. With `ACTIVE_HIGH`=0, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | NUM_EVENTS | Event levels |
| ev_en | input | NUM_EVENTS | Per-event enable |
| trig_time | input | 3 | Qualification time code |
| pulse_code | input | 2 | Pulse width code |
| tb_tick | input | 1 | One-cycle time-base tick, once per 0.5 ms |
| rst_out | output | 1 | Registered reset pulse at the active level |

## Verification
The state and the output register update at the same clock edge, so every result is due one edge after the stimulus that causes it. For coincidence, release or the last tick of a count, the output is therefore correct at the following falling edge. The bench drives inputs and samples `rst_out` only on falling edges. It issues each tick as a one-cycle pulse followed by its own sampling point. This lets it compare the output against the tick index, computed from H(c) and the width table, after every single tick.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_QUAL  = 2'd1,
        S_PULSE = 2'd2,
        S_REARM = 2'd3
    } rstgen_state_e;

    // Qualification time in half-second units for a 3-bit code.
    function automatic int qual_halves(input logic [2:0] code);
        return (code == 3'd0) ? 0 : int'(code) + 1;
    endfunction

    // Pulse width in half-millisecond units for a 2-bit code.
    function automatic int width_units(input logic [1:0] code);
        int u;
        unique case (code)
            2'd0: u = 1;
            2'd1: u = 2;
            2'd2: u = 10;
            default: u = 20;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/rstgen_coincide.sv
module rstgen_coincide #(
    parameter int N = 3
) (
    input  logic [N-1:0] ev_in,
    input  logic [N-1:0] ev_en,
    output logic         all_hit,
    output logic         any_hit
);
    logic [N-1:0] masked;

    always_comb begin
        masked  = ev_in & ev_en;
        all_hit = (|ev_en) && (masked == ev_en);
        any_hit = |masked;
    end

    // R1: full coincidence always implies at least one enabled event is high
    always_comb begin
        a_r1_all_implies_any: assert (!all_hit || any_hit);
    end
endmodule

// File: rtl/rstgen_tick_counter.sv
module rstgen_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_next_w;

    always_comb begin
        cnt_next_w = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
        done       = step && (cnt_next_w >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr)        cnt_q <= '0;
        else if (step && !done) cnt_q <= cnt_next_w[W-1:0];
    end

    // R3/R5: a tick that does not finish the count advances it by exactly one
    a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R4: a clear request leaves the count at zero
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/coincident_reset_gen.sv
module coincident_reset_gen
    import rstgen_pkg::*;
#(
    parameter int NUM_EVENTS         = 3,
    parameter int TICKS_PER_HALF_SEC = 1000,
    parameter int TICKS_PER_HALF_MS  = 1,
    parameter bit ACTIVE_HIGH        = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_in,
    input  logic [NUM_EVENTS-1:0] ev_en,
    input  logic [2:0]            trig_time,
    input  logic [1:0]            pulse_code,
    input  logic                  tb_tick,
    output logic                  rst_out
);
    localparam int QMAX = 8 * TICKS_PER_HALF_SEC;
    localparam int QW   = $clog2(QMAX + 1);
    localparam int WMAX = 20 * TICKS_PER_HALF_MS;
    localparam int WW   = $clog2(WMAX + 1);
    localparam logic IDLE_LVL = ~ACTIVE_HIGH;

    rstgen_state_e state_q, state_d;
    logic          all_hit, any_hit;
    logic [QW-1:0] qual_limit;
    logic [WW-1:0] width_limit;
    logic          qual_done, width_done;
    logic          qual_zero;

    always_comb begin
        qual_limit  = QW'(qual_halves(trig_time) * TICKS_PER_HALF_SEC);
        width_limit = WW'(width_units(pulse_code) * TICKS_PER_HALF_MS);
        qual_zero   = (qual_limit == '0);
    end

    rstgen_coincide #(.N(NUM_EVENTS)) coin_i (
        .ev_in   (ev_in),
        .ev_en   (ev_en),
        .all_hit (all_hit),
        .any_hit (any_hit)
    );

    rstgen_tick_counter #(.W(QW)) qual_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_QUAL || !all_hit),
        .step  (state_q == S_QUAL && all_hit && tb_tick),
        .limit (qual_limit),
        .done  (qual_done)
    );

    rstgen_tick_counter #(.W(WW)) width_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != S_PULSE),
        .step  (state_q == S_PULSE && tb_tick),
        .limit (width_limit),
        .done  (width_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (all_hit) state_d = qual_zero ? S_PULSE : S_QUAL;
            end
            S_QUAL: begin
                if (!all_hit)       state_d = S_IDLE;
                else if (qual_done) state_d = S_PULSE;
            end
            S_PULSE: begin
                if (width_done) state_d = S_REARM;
            end
            S_REARM: begin
                if (!any_hit) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output register: changes on the same edge as the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_out <= IDLE_LVL;
        else        rst_out <= (state_d == S_PULSE) ? ACTIVE_HIGH : IDLE_LVL;
    end

    // R1: entering the pulse needs coincidence in the cycle before
    a_r1_pulse_needs_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PULSE && state_d == S_PULSE) |-> all_hit);

    // R2: with nothing enabled no pulse can start
    a_r2_no_enable_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PULSE && ev_en == '0) |=> (state_q != S_PULSE));

    // R4: loss of coincidence while qualifying returns to idle
    a_r4_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_QUAL && !all_hit) |=> (state_q == S_IDLE));

    // R6: lock-out holds while any enabled event remains high
    a_r6_rearm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REARM && any_hit) |=> (state_q == S_REARM));

    // R9: output level agrees with the pulse state
    a_r9_level_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out == ACTIVE_HIGH) == (state_q == S_PULSE));
endmodule

// File: tb/coincident_reset_gen_tb_top.sv
module coincident_reset_gen_tb_top;
    import rstgen_pkg::*;

    localparam int TPH  = 2;
    localparam int TPMS = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_tick = 1'b0;
    logic [2:0] ev_in = '0, ev_en = '0;
    logic [1:0] ev2_in = '0, ev2_en = '0;
    logic [2:0] trig_time = '0, trig2 = '0;
    logic [1:0] pulse_code = '0, pulse2 = '0;
    logic       rst_out, rst2_out;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    coincident_reset_gen #(.NUM_EVENTS(3), .TICKS_PER_HALF_SEC(TPH),
        .TICKS_PER_HALF_MS(TPMS), .ACTIVE_HIGH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .ev_en(ev_en),
        .trig_time(trig_time), .pulse_code(pulse_code),
        .tb_tick(tb_tick), .rst_out(rst_out));

    coincident_reset_gen #(.NUM_EVENTS(2), .TICKS_PER_HALF_SEC(TPH),
        .TICKS_PER_HALF_MS(TPMS), .ACTIVE_HIGH(1'b0)) dut2_i (
        .clk(clk), .rst_n(rst_n), .ev_in(ev2_in), .ev_en(ev2_en),
        .trig_time(trig2), .pulse_code(pulse2),
        .tb_tick(tb_tick), .rst_out(rst2_out));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick();
        tb_tick = 1'b1;
        @(negedge clk);
        tb_tick = 1'b0;
    endtask

    function automatic int qual_ticks(input int c);
        return (c == 0) ? 0 : (c + 1) * TPH;
    endfunction

    function automatic int width_ticks(input int p);
        int t[4] = '{1, 2, 10, 20};
        return t[p] * TPMS;
    endfunction

    // Full trigger run on dut_i: qualify, pulse, lock-out, release.
    task automatic run_code(input int c, input int p);
        int q, w;
        q = qual_ticks(c);
        w = width_ticks(p);
        trig_time  = 3'(c);
        pulse_code = 2'(p);
        ev_en = 3'b111;
        ev_in = 3'b111;
        step();
        if (q == 0) chk(rst_out == 1'b1, "R3 code0 immediate", rst_out, 1);
        else begin
            chk(rst_out == 1'b0, "R3 not yet", rst_out, 0);
            for (int i = 1; i <= q; i++) begin
                tick();
                chk(rst_out == (i == q), "R3 qual tick", rst_out, int'(i == q));
            end
        end
        for (int j = 1; j <= w; j++) begin
            tick();
            chk(rst_out == (j < w), "R5 width tick", rst_out, int'(j < w));
        end
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(rst_out == 1'b0, "R6 held no refire", rst_out, 0);
        end
        ev_in = 3'b000;
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R7: reset state
        ev_en = 3'b111; ev_in = 3'b111;
        repeat (3) step();
        chk(rst_out == 1'b0, "R7 in reset", rst_out, 0);
        chk(rst2_out == 1'b1, "R7 R9 in reset low-active", rst2_out, 1);
        ev_en = '0; ev_in = '0;
        rst_n = 1'b1;
        step();
        chk(rst_out == 1'b0, "R7 after reset", rst_out, 0);

        // R3 R5 R6: sweep every trigger code with each width code
        for (int c = 0; c < 8; c++) run_code(c, c % 4);

        // R4: drop before expiry restarts the count
        trig_time = 3'd2; pulse_code = 2'd0;
        ev_en = 3'b111; ev_in = 3'b111;
        step();
        repeat (4) tick();
        ev_in = 3'b110; step();
        ev_in = 3'b111; step();
        for (int i = 1; i <= 5; i++) tick();
        chk(rst_out == 1'b0, "R4 restarted count", rst_out, 0);
        tick();
        chk(rst_out == 1'b1, "R4 fires after full time", rst_out, 1);
        tick();
        chk(rst_out == 1'b0, "R4 R5 pulse end", rst_out, 0);

        // R6: partial release does not re-arm
        ev_in = 3'b110; step();
        ev_in = 3'b111; step();
        for (int i = 0; i < 8; i++) tick();
        chk(rst_out == 1'b0, "R6 partial release", rst_out, 0);
        ev_in = 3'b000; step();
        ev_in = 3'b111; step();
        for (int i = 0; i < 6; i++) tick();
        chk(rst_out == 1'b1, "R6 full release rearms", rst_out, 1);
        tick();
        ev_in = 3'b000; step();

        // R1: disabled event ignored, enabled event missing blocks
        trig_time = 3'd1; pulse_code = 2'd0;
        ev_en = 3'b101; ev_in = 3'b101; step();
        for (int i = 0; i < 4; i++) tick();
        chk(rst_out == 1'b1, "R1 disabled bit ignored", rst_out, 1);
        tick();
        ev_in = 3'b000; step();
        ev_in = 3'b100; step();
        for (int i = 0; i < 10; i++) tick();
        chk(rst_out == 1'b0, "R1 missing enabled event", rst_out, 0);
        ev_in = 3'b000; step();

        // R2: nothing enabled never fires
        trig_time = 3'd0; ev_en = 3'b000; ev_in = 3'b111;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(rst_out == 1'b0, "R2 no enable", rst_out, 0);
        end
        ev_in = 3'b000; step();

        // R8 R9: two-event instance, active-low output
        trig2 = 3'd1; pulse2 = 2'd1;
        ev2_en = 2'b11; ev2_in = 2'b11; step();
        for (int i = 1; i <= 4; i++) begin
            tick();
            chk(rst2_out == (i != 4), "R8 R9 qual", rst2_out, int'(i != 4));
        end
        for (int j = 1; j <= 2; j++) begin
            tick();
            chk(rst2_out == (j == 2), "R8 R9 width", rst2_out, int'(j == 2));
        end
        ev2_in = 2'b01; step();
        for (int i = 0; i < 6; i++) tick();
        chk(rst2_out == 1'b1, "R8 missing event", rst2_out, 1);
        chk(rst_out == 1'b0, "R8 other instance idle", rst_out, 0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule